// File: doc/BRIEF.md
# Column-Summing Unsigned Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It does not add row-shifted partial-product vectors. It works on weight columns instead. Column k sums every single-bit partial product a[i]&b[j] with i+j=k, plus a multi-bit carry handed over from column k-1. The least significant bit of that sum is product bit k, and the remaining bits pass to column k+1. Column 0 starts with a zero carry. The carry out of the last column (2W-2) supplies the top product bit.

Operands enter on a valid/ready stream and the product leaves on another. By default one register stage holds the accepted operand pair, so a product appears one cycle after acceptance. The stage moves forward when it is empty or when the consumer takes its current result. A stalled consumer therefore stalls the producer in the same cycle, and no operand pair is lost. If out_valid is high while out_ready is low, the product and out_valid stay unchanged. A parameter removes the stage, which turns the block into a purely combinational path where in_ready follows out_ready.

Top module: `colmul_top`

## Requirements
- R1: For every operand pair accepted, out_product equals in_a multiplied by in_b as unsigned integers, 2W bits wide (W=8: all 65536 pairs).
- R2: Product bit 0 equals in_a[0] AND in_b[0].
- R3: The heaviest carry patterns are exact: 255*255 gives 65025 and 191*255 gives 48705.
- R4: A zero in either operand gives a product of zero.
- R5: With the register stage present, out_valid is high in the cycle after any handshake on the input side.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_product does not change in the next cycle.
- R7: in_ready is high exactly when no result is held or the held result is taken in the same cycle (in_ready = !out_valid || out_ready).
- R8: While rst_n is low, out_valid is low and in_ready is high.
- R9: The carry forwarded between columns never exceeds W-1, so the carry out of the last column is a single bit: the product's MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | out_product holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_product | output | 2W | Unsigned product |

## Verification
The bench sends every one of the 65536 operand pairs. A stall pattern on the consumer side and gaps on the producer side cover the back-pressure and hold rules. A carry chain that is too narrow, or a column that misses a term, would break the all-ones and 191*255 products first, because they load the middle columns most heavily. A wrong ready rule or hold rule would drop or duplicate items, and the scoreboard queue would then lose alignment with the outputs. A column index that is off by one would corrupt products that contain only a few set bits, and the zero-operand cases and the bit 0 check catch those.

// File: rtl/colmul_pkg.sv
package colmul_pkg;
  // Bits needed for the carry passed between columns; carry never exceeds w-1.
  function automatic int carry_bits(input int w);
    int n;
    n = $clog2(w);
    return (n < 1) ? 1 : n;
  endfunction

  // Number of partial products landing in column k of a w x w array.
  function automatic int col_terms(input int w, input int k);
    return (k < w) ? k + 1 : 2 * w - 1 - k;
  endfunction

  // Lowest multiplicand index contributing to column k.
  function automatic int col_first(input int w, input int k);
    return (k < w) ? 0 : k - w + 1;
  endfunction
endpackage

// File: rtl/colmul_ppgen.sv
module colmul_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0][W-1:0]  pp
);
  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_bit
      assign pp[i][j] = a[i] & b[j];
    end
  end
endmodule

// File: rtl/colmul_column.sv
module colmul_column #(
  parameter int NT = 1,
  parameter int CW = 3
) (
  input  logic [NT-1:0] terms,
  input  logic [CW-1:0] carry_in,
  output logic          res_bit,
  output logic [CW-1:0] carry_out
);
  localparam int SW = CW + 1;

  logic [SW-1:0] total;

  always_comb begin
    total = SW'(carry_in);
    for (int t = 0; t < NT; t++) begin
      total = total + SW'(terms[t]);
    end
  end

  assign res_bit   = total[0];
  assign carry_out = total[SW-1:1];
endmodule

// File: rtl/colmul_core.sv
module colmul_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p,
  output logic [colmul_pkg::carry_bits(W)-2:0] spill
);
  localparam int NCOL = 2 * W - 1;
  localparam int CW   = colmul_pkg::carry_bits(W);

  logic [W-1:0][W-1:0] pp;
  logic [CW-1:0]       chain [NCOL+1];

  colmul_ppgen #(.W(W)) u_ppgen (
    .a  (a),
    .b  (b),
    .pp (pp)
  );

  assign chain[0] = '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    localparam int NT = colmul_pkg::col_terms(W, k);
    localparam int I0 = colmul_pkg::col_first(W, k);
    logic [NT-1:0] terms;
    for (genvar t = 0; t < NT; t++) begin : g_term
      assign terms[t] = pp[I0 + t][k - I0 - t];
    end
    colmul_column #(.NT(NT), .CW(CW)) u_col (
      .terms     (terms),
      .carry_in  (chain[k]),
      .res_bit   (p[k]),
      .carry_out (chain[k+1])
    );
  end

  assign p[2*W-1] = chain[NCOL][0];
  assign spill    = chain[NCOL][CW-1:1];
endmodule

// File: rtl/colmul_top.sv
module colmul_top #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_product
);
  localparam int PW = 2 * W;
  localparam int CW = colmul_pkg::carry_bits(W);

  logic [W-1:0]  core_a;
  logic [W-1:0]  core_b;
  logic [CW-2:0] spill;

  colmul_core #(.W(W)) u_core (
    .a     (core_a),
    .b     (core_b),
    .p     (out_product),
    .spill (spill)
  );

  if (REGISTERED) begin : g_reg
    logic         held;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;

    assign in_ready  = !held || out_ready;
    assign out_valid = held;
    assign core_a    = op_a;
    assign core_b    = op_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held <= 1'b0;
        op_a <= '0;
        op_b <= '0;
      end else if (in_ready) begin
        held <= in_valid;
        if (in_valid) begin
          op_a <= in_a;
          op_b <= in_b;
        end
      end
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_product == PW'(op_a) * PW'(op_b)); // R1
    AST_LSB_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_product[0] == (op_a[0] & op_b[0])); // R2
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R5
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_product)); // R6
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R7
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid); // R8
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign core_a    = in_a;
    assign core_b    = in_b;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    spill == '0); // R9
endmodule

// File: tb/test_colmul_top.sv
module test_colmul_top;
  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int NPAIRS = 1 << PW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [W-1:0]   in_a;
  logic [W-1:0]   in_b;
  logic           out_valid;
  logic           out_ready;
  logic [PW-1:0]  out_product;

  always #10 clk = ~clk;

  colmul_top #(.W(W), .REGISTERED(1'b1)) i_colmul_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_product (out_product)
  );

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [PW-1:0] sb_q[$];

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: pushes expected operand pairs into the scoreboard on acceptance.
  // Monitor: pops and compares on each output transfer.
  initial begin
    int idx  = 0;
    int cyc  = 0;
    bit prev_stall  = 1'b0;
    bit prev_accept = 1'b0;
    logic [PW-1:0] prev_prod = '0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_a      = '0;
    in_b      = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", PW'(out_valid), '0);
    check(in_ready == 1'b1, "R8", PW'(in_ready), 1);
    rst_n = 1'b1;

    while (idx < NPAIRS || sb_q.size() > 0 || in_valid) begin
      @(negedge clk);
      cyc++;
      if (prev_accept) in_valid = 1'b0;
      if (prev_stall) begin
        check(out_valid == 1'b1, "R6", PW'(out_valid), 1);
        check(out_product == prev_prod, "R6", out_product, prev_prod);
      end
      if (prev_accept) check(out_valid == 1'b1, "R5", PW'(out_valid), 1);
      out_ready = !((cyc % 7) == 3 || (cyc % 13) == 5);
      if (!in_valid && idx < NPAIRS && (cyc % 11) != 0) begin
        in_valid = 1'b1;
        in_a = idx[15:8];
        in_b = idx[7:0];
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R7", PW'(in_ready),
            PW'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1 unexpected output", out_product, '0);
        end else begin
          logic [PW-1:0] pair;
          logic [W-1:0] ea;
          logic [W-1:0] eb;
          logic [PW-1:0] exp;
          string tag;
          pair = sb_q.pop_front();
          ea   = pair[PW-1:W];
          eb   = pair[W-1:0];
          exp  = PW'(ea) * PW'(eb);
          if ((ea == 8'd255 && eb == 8'd255) || (ea == 8'd191 && eb == 8'd255))
            tag = "R3";
          else if (ea == 0 || eb == 0)
            tag = "R4";
          else
            tag = "R1 R9";
          check(out_product == exp, tag, out_product, exp);
          check(out_product[0] == (ea[0] & eb[0]), "R2", PW'(out_product[0]),
                PW'(ea[0] & eb[0]));
        end
      end
      prev_accept = in_valid && in_ready;
      if (prev_accept) begin
        sb_q.push_back({in_a, in_b});
        idx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_prod  = out_product;
    end
    check(sb_q.size() == 0, "R1 drain", PW'(sb_q.size()), '0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end
endmodule